// File: doc/BRIEF.md
# Microcode Sequencer with Flag-Banked Control Store

This block is the control unit of a small microcoded processor. It keeps a 4-bit micro-step counter, a 16-bit instruction register and a writable control store of 32-bit control words. On every falling clock edge it first advances the step counter. It then forms a 16-bit store address from two status flags, the low ten instruction-register bits and the advanced step, reads the control word there, and registers it on the same edge. The datapath acts on the registered word at the next rising edge. The instruction register is the only datapath register held here. It loads from the data bus on a rising edge when the registered word asks for it.

Two bits of the control word steer the step counter through three named actions. ADVANCE keeps the incremented value. CLEAR forces the step to 0 (bit 30). JUMP forces it to 8 (bit 31), and JUMP wins when both bits are set. The action is picked from the word just fetched and is applied on that same falling edge. The two flags choose one of four banks of microcode, so one opcode can branch on carry or zero without extra steps.

The store is filled through a synchronous write port that takes addresses in the same 16-bit map. To keep simulation small, only the low `IR_SEL_W` instruction bits are populated. A write whose unpopulated instruction-field bits are nonzero is dropped.

Top module: `uc_sequencer`

## Requirements
- R1: While rst_n is low, ctrl_o, step_o and ir_o are all zero.
- R2: uc_addr_o shows the address of the most recent fetch. Its bits 15:14 are the flags, bits 13:4 are instruction-register bits 9:0, and bits 3:0 are the step value used for the lookup.
- R3: On each falling edge the step counter is incremented before the lookup, so the fetch uses the old step plus one. When neither force bit is set, step_o then equals that looked-up step.
- R4: If the fetched word has bit 30 set and bit 31 clear, step_o is 0 after that falling edge.
- R5: If the fetched word has bit 31 set, step_o is 8 after that falling edge, whatever the value of bit 30.
- R6: With no force bit set, the step wraps from 15 to 0.
- R7: Different flag values fetch from different banks for the same instruction and step.
- R8: ctrl_o changes only on falling edges. A rising edge leaves it unchanged.
- R9: On a rising edge, ir_o loads bus_i when bit 29 of ctrl_o is set. Otherwise it holds, whatever bus_i carries.
- R10: A write with uc_we_i high updates the store on the rising edge. Later fetches of that address return the new word.
- R11: A write whose address bits 13:(4+IR_SEL_W) are not all zero is dropped. The aliased entry keeps its old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: rising edge for datapath actions and store writes, falling edge for fetch |
| rst_n | input | 1 | Asynchronous active-low reset |
| flags_i | input | 2 | Status flags that select the microcode bank |
| bus_i | input | 16 | Data bus value for instruction-register loads |
| uc_we_i | input | 1 | Control store write enable |
| uc_waddr_i | input | 16 | Control store write address, in the 16-bit fetch map |
| uc_wdata_i | input | 32 | Control store write data |
| ctrl_o | output | 32 | Registered control word |
| step_o | output | 4 | Current micro-step |
| ir_o | output | 16 | Instruction register |
| uc_addr_o | output | 16 | Address of the most recent fetch |

## Verification
The step assertions assume that every store entry that can be fetched has been written before reset is released, so the force bits are never unknown. The bench meets this by filling all populated entries while reset is held. The instruction-register assertion assumes bus_i and the control word are stable across each rising edge. The bench drives all inputs one nanosecond after a rising edge, keeps instruction-register loads within the populated range (bus bits 9:4 zero), and keeps any write in the middle of a run clear of the address fetched on the same falling edge.

// File: rtl/uc_seq_pkg.sv
package uc_seq_pkg;

    localparam int unsigned CW_W       = 32;
    localparam int unsigned STEP_W     = 4;
    localparam int unsigned FLAG_W     = 2;
    localparam int unsigned IR_W       = 16;
    localparam int unsigned IR_FIELD_W = 10;
    localparam int unsigned UADDR_W    = FLAG_W + IR_FIELD_W + STEP_W;

    // control word bits consumed inside the sequencer
    localparam int unsigned CW_IR_LOAD  = 29;
    localparam int unsigned CW_STEP_CLR = 30;
    localparam int unsigned CW_STEP_JMP = 31;

    localparam logic [STEP_W-1:0] STEP_JUMP_TARGET = STEP_W'(8);

    typedef logic [CW_W-1:0] cword_t;

    typedef enum logic [1:0] {
        STEP_ADVANCE = 2'd0,
        STEP_CLEAR   = 2'd1,
        STEP_JUMP    = 2'd2
    } step_act_e;

endpackage

// File: rtl/uc_addr_gen.sv
module uc_addr_gen
    import uc_seq_pkg::*;
(
    input  logic [FLAG_W-1:0]     flags,
    input  logic [IR_FIELD_W-1:0] ir_field,
    input  logic [STEP_W-1:0]     step_nx,
    output logic [UADDR_W-1:0]    addr
);

    // bank (flags) on top, opcode in the middle, step at the bottom
    assign addr = {flags, ir_field, step_nx};

endmodule

// File: rtl/uc_store.sv
module uc_store
    import uc_seq_pkg::*;
#(
    parameter int unsigned IR_SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [UADDR_W-1:0]   waddr,
    input  cword_t               wdata,
    input  logic [FLAG_W+IR_SEL_W+STEP_W-1:0] ridx,
    output cword_t               rdata
);

    localparam int unsigned IDX_W = FLAG_W + IR_SEL_W + STEP_W;
    localparam int unsigned DEPTH = 1 << IDX_W;

    cword_t           mem [DEPTH];
    logic [IDX_W-1:0] widx;
    logic             wr_ok;

    assign widx = {waddr[UADDR_W-1 -: FLAG_W],
                   waddr[STEP_W+IR_SEL_W-1:STEP_W],
                   waddr[STEP_W-1:0]};

    generate
        if (IR_SEL_W < IR_FIELD_W) begin : g_partial
            assign wr_ok = we &&
                (waddr[UADDR_W-FLAG_W-1:STEP_W+IR_SEL_W] == '0);
        end else begin : g_full
            assign wr_ok = we;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/uc_step_ctrl.sv
module uc_step_ctrl
    import uc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_req,
    input  logic               jmp_req,
    input  cword_t             cw_live,
    input  logic [UADDR_W-1:0] addr_live,
    output logic [STEP_W-1:0]  step_q,
    output logic [STEP_W-1:0]  step_inc
);

    step_act_e         act;
    logic [STEP_W-1:0] step_d;

    assign step_inc = step_q + 1'b1;

    // action select: jump outranks clear
    always_comb begin
        unique case ({jmp_req, clr_req})
            2'b00:        act = STEP_ADVANCE;
            2'b01:        act = STEP_CLEAR;
            2'b10, 2'b11: act = STEP_JUMP;
            default:      act = STEP_ADVANCE;
        endcase
    end

    always_comb begin
        unique case (act)
            STEP_ADVANCE: step_d = step_inc;
            STEP_CLEAR:   step_d = '0;
            STEP_JUMP:    step_d = STEP_JUMP_TARGET;
            default:      step_d = step_inc;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else begin
            step_q <= step_d;
        end
    end

    // shadow of the previous step, used only by the checks below
    logic [STEP_W-1:0] step_prev;
    logic              fetched;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_prev <= '0;
            fetched   <= 1'b0;
        end else begin
            step_prev <= step_q;
            fetched   <= 1'b1;
        end
    end

    AST_STEP_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        cw_live[CW_STEP_JMP] |-> step_q == STEP_JUMP_TARGET); // R5

    AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_live[CW_STEP_CLR] && !cw_live[CW_STEP_JMP]) |-> step_q == '0); // R4

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetched && !cw_live[CW_STEP_CLR] && !cw_live[CW_STEP_JMP])
        |-> step_q == STEP_W'(step_prev + 1'b1)); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cw_live[CW_STEP_CLR] && !cw_live[CW_STEP_JMP])
        |-> addr_live[STEP_W-1:0] == step_q); // R3

endmodule

// File: rtl/uc_sequencer.sv
module uc_sequencer
    import uc_seq_pkg::*;
#(
    parameter int unsigned IR_SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FLAG_W-1:0]    flags_i,
    input  logic [IR_W-1:0]      bus_i,
    input  logic                 uc_we_i,
    input  logic [UADDR_W-1:0]   uc_waddr_i,
    input  logic [CW_W-1:0]      uc_wdata_i,
    output logic [CW_W-1:0]      ctrl_o,
    output logic [STEP_W-1:0]    step_o,
    output logic [IR_W-1:0]      ir_o,
    output logic [UADDR_W-1:0]   uc_addr_o
);

    localparam int unsigned IDX_W = FLAG_W + IR_SEL_W + STEP_W;

    logic [STEP_W-1:0]  step_q;
    logic [STEP_W-1:0]  step_inc;
    logic [UADDR_W-1:0] fetch_addr;
    logic [IDX_W-1:0]   ridx;
    cword_t             rdata;
    cword_t             ctrl_q;
    logic [UADDR_W-1:0] addr_q;
    logic [IR_W-1:0]    ir_q;

    uc_addr_gen u_addr (
        .flags    (flags_i),
        .ir_field (ir_q[IR_FIELD_W-1:0]),
        .step_nx  (step_inc),
        .addr     (fetch_addr)
    );

    assign ridx = {fetch_addr[UADDR_W-1 -: FLAG_W],
                   fetch_addr[STEP_W+IR_SEL_W-1:STEP_W],
                   fetch_addr[STEP_W-1:0]};

    uc_store #(.IR_SEL_W(IR_SEL_W)) u_store (
        .clk   (clk),
        .we    (uc_we_i),
        .waddr (uc_waddr_i),
        .wdata (uc_wdata_i),
        .ridx  (ridx),
        .rdata (rdata)
    );

    uc_step_ctrl u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_req   (rdata[CW_STEP_CLR]),
        .jmp_req   (rdata[CW_STEP_JMP]),
        .cw_live   (ctrl_q),
        .addr_live (addr_q),
        .step_q    (step_q),
        .step_inc  (step_inc)
    );

    // fetch register: loaded on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            addr_q <= '0;
        end else begin
            ctrl_q <= rdata;
            addr_q <= fetch_addr;
        end
    end

    // instruction register: acts on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ctrl_q[CW_IR_LOAD]) begin
            ir_q <= bus_i;
        end
    end

    assign ctrl_o    = ctrl_q;
    assign step_o    = step_q;
    assign ir_o      = ir_q;
    assign uc_addr_o = addr_q;

    AST_IR_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
        !ctrl_q[CW_IR_LOAD] |-> $stable(ir_q)); // R9

endmodule

// File: tb/uc_sequencer_tb.sv
`timescale 1ns/1ps
module uc_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  flags_i;
    logic [15:0] bus_i;
    logic        uc_we_i;
    logic [15:0] uc_waddr_i;
    logic [31:0] uc_wdata_i;
    logic [31:0] ctrl_o;
    logic [3:0]  step_o;
    logic [15:0] ir_o;
    logic [15:0] uc_addr_o;

    always #2 clk = ~clk;   // 250 MHz

    uc_sequencer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_i    (flags_i),
        .bus_i      (bus_i),
        .uc_we_i    (uc_we_i),
        .uc_waddr_i (uc_waddr_i),
        .uc_wdata_i (uc_wdata_i),
        .ctrl_o     (ctrl_o),
        .step_o     (step_o),
        .ir_o       (ir_o),
        .uc_addr_o  (uc_addr_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] over_mem [logic [15:0]];
    string       tag_at   [logic [15:0]];

    logic [31:0] q_w   [$];
    logic [15:0] q_a   [$];
    logic [3:0]  q_s   [$];
    logic [15:0] q_ir  [$];
    string       q_tag [$];

    logic [3:0]  m_step = '0;
    logic [15:0] m_ir   = '0;
    logic [1:0]  m_prev_flags = '0;
    logic [31:0] last_w = '0;

    function automatic logic [31:0] pat(input logic [15:0] a);
        logic [31:0] w;
        w = {3'b000, 13'(a ^ 16'h1357), a};
        case (a[15:14])
            2'd1: w[29] = 1'b1;
            2'd2: w[30] = 1'b1;
            2'd3: begin w[31] = 1'b1; w[30] = a[0]; end
            default: ;
        endcase
        return w;
    endfunction

    function automatic logic [31:0] model_rd(input logic [15:0] a);
        if (over_mem.exists(a)) return over_mem[a];
        return pat(a);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: sets inputs, predicts the next falling-edge fetch, pushes it
    task automatic do_cycle(input logic [1:0] fl, input logic [15:0] bus,
                            input bit we, input logic [15:0] wa,
                            input logic [31:0] wd);
        logic [3:0]  nxt;
        logic [15:0] a;
        logic [31:0] w;
        logic [3:0]  s_after;
        string       tg;
        flags_i = fl; bus_i = bus;
        uc_we_i = we; uc_waddr_i = wa; uc_wdata_i = wd;
        nxt = m_step + 4'd1;
        a   = {fl, m_ir[9:0], nxt};
        w   = model_rd(a);
        if (tag_at.exists(a))      tg = tag_at[a];
        else if (fl != m_prev_flags) tg = "R7";
        else if (w[31])            tg = "R5";
        else if (w[30])            tg = "R4";
        else if (last_w[29])       tg = "R9";
        else if (nxt == 4'd0)      tg = "R6";
        else                       tg = "R3";
        s_after = w[31] ? 4'd8 : (w[30] ? 4'd0 : nxt);
        q_w.push_back(w); q_a.push_back(a); q_s.push_back(s_after);
        q_ir.push_back(m_ir); q_tag.push_back(tg);
        m_step = s_after;
        if (w[29]) m_ir = bus;
        if (we && wa[13:8] == 6'd0) over_mem[wa] = wd;
        m_prev_flags = fl;
        @(posedge clk); #1;
        check("R8", "ctrl held across rising edge", ctrl_o, w);
        uc_we_i = 1'b0;
        last_w = w;
    endtask

    // monitor: compares each fetch just after the falling edge
    initial begin
        forever begin
            @(negedge clk); #1;
            if (q_w.size() > 0) begin
                logic [31:0] w;  logic [15:0] a;  logic [3:0] s;
                logic [15:0] ir; string tg;
                w = q_w.pop_front(); a = q_a.pop_front(); s = q_s.pop_front();
                ir = q_ir.pop_front(); tg = q_tag.pop_front();
                check(tg,   "control word", ctrl_o, w);
                check("R2", "fetch address", {16'd0, uc_addr_o}, {16'd0, a});
                check(tg,   "step", {28'd0, step_o}, {28'd0, s});
                check("R9", "instruction register", {16'd0, ir_o}, {16'd0, ir});
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; flags_i = '0; bus_i = 16'hA5A5;
        uc_we_i = 1'b0; uc_waddr_i = '0; uc_wdata_i = '0;
        @(posedge clk); #1;
        // preload every populated entry while reset is held
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < 16; i++) begin
                for (int s = 0; s < 16; s++) begin
                    uc_we_i    = 1'b1;
                    uc_waddr_i = {2'(f), 6'd0, 4'(i), 4'(s)};
                    uc_wdata_i = pat(uc_waddr_i);
                    @(posedge clk); #1;
                end
            end
        end
        // R11: alias write with bit 8 set must be dropped
        uc_waddr_i = 16'h0105; uc_wdata_i = 32'h0EEE_EEEE;
        tag_at[16'h0005] = "R11";
        @(posedge clk); #1;
        uc_we_i = 1'b0;
        // R1: reset state
        check("R1", "ctrl in reset", ctrl_o, 32'd0);
        check("R1", "step in reset", {28'd0, step_o}, 32'd0);
        check("R1", "ir in reset", {16'd0, ir_o}, 32'd0);
        rst_n = 1'b1;

        // bank 0, opcode 0: plain advance and wrap; R10 write in the middle
        for (int k = 0; k < 20; k++) begin
            if (k == 3) begin
                tag_at[16'h000A] = "R10";
                do_cycle(2'd0, 16'(k * 16'h1111), 1'b1, 16'h000A, 32'h0BAD_F00D);
            end else begin
                do_cycle(2'd0, 16'(k * 16'h1111), 1'b0, 16'h0, 32'h0);
            end
        end
        // bank 1: every word loads the instruction register
        for (int k = 0; k < 10; k++)
            do_cycle(2'd1, {6'(k + 1), 6'd0, 4'(k * 3 + 1)}, 1'b0, 16'h0, 32'h0);
        // bank 0 with a nonzero opcode; bus changes must be ignored
        for (int k = 0; k < 4; k++)
            do_cycle(2'd0, 16'(16'hF00F - k), 1'b0, 16'h0, 32'h0);
        // bank 2: clear every step
        for (int k = 0; k < 4; k++)
            do_cycle(2'd2, 16'h0000, 1'b0, 16'h0, 32'h0);
        // bank 3: jump every step, odd steps also request clear
        for (int k = 0; k < 5; k++)
            do_cycle(2'd3, 16'h0000, 1'b0, 16'h0, 32'h0);
        for (int k = 0; k < 3; k++)
            do_cycle(2'd0, 16'h0000, 1'b0, 16'h0, 32'h0);

        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule